// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block carries out exception entry and exception return for a 32-bit processor core. On entry it takes a request that holds a vector number and, for hardware interrupts, a priority level. It writes a frame of two longwords to the supervisor stack. The first longword is the return PC. The second is a format word that records the vector offset, the old status register, and the two low bits of the stack pointer. It then reads the handler address from the vector table and hands a new PC, SR and SP back to the core.

On a return request it reads the frame back and rebuilds the three registers. The rebuilt SP is exact even when the original SP was not longword aligned.

All memory traffic uses a single 32-bit longword port with a valid/ready handshake. The core supplies the stack pointer that applies in supervisor mode. The block accepts one request at a time and reports completion with a one-cycle pulse.

Top module: `exc_frame_seq`

## Requirements
- R1: The format word pushed on entry has bits 31:28 equal to 0x4 with bits 29:28 then replaced by SP[1:0]. Bits 27:26 are zero, the vector offset (vector×4) sits from bit 16 upward, and bits 15:0 hold the SR as it was before entry.
- R2: Entry forces SP down to a multiple of 4, giving SPa. It writes the return PC to SPa−4 and then the format word to SPa−8, in that order. The SP handed back is SPa−8, and every memory address has bits 1:0 equal to zero.
- R3: After both writes, entry reads one longword at VBR + vector×4, and that value becomes the new PC.
- R4: The SR returned on entry always has bit 13 (supervisor) set. For a hardware interrupt, bits 10:8 (interrupt mask) also take the accepted level and bit 12 (master) is cleared. Other entries leave the remaining SR bits unchanged.
- R5: A hardware interrupt request is taken only when its level is strictly greater than SR bits 10:8. Otherwise it is dropped: busy stays low and no memory access is made.
- R6: When the trap flag is set, the stacked return PC is the current PC plus 2. Otherwise it is the current PC.
- R7: A return request reads the format word at SP and then the PC at SP+4. It hands back PC from the second read, SR from format bits 15:0, and SP = (SP OR format[29:28]) + 8.
- R8: A memory request stays asserted, with address, write flag and write data held steady, until ready is seen. The sequence does not advance before then.
- R9: Busy is high from the cycle after a request is taken until the cycle after done. Done is a single-cycle pulse during which next_pc, next_sr and next_sp are valid. Requests that arrive while busy are ignored.
- R10: After reset, busy, done and mem_valid are low.
- R11: If an acceptable exception request and a return request arrive together, the exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception or interrupt request |
| exc_vector | input | VEC_W | Vector number |
| exc_irq | input | 1 | Request is a hardware interrupt |
| exc_level | input | 3 | Interrupt level |
| exc_trap | input | 1 | Request comes from a trap instruction |
| rte_valid | input | 1 | Return-from-exception request |
| cur_pc | input | 32 | PC at the request |
| cur_sr | input | 16 | SR at the request |
| cur_sp | input | 32 | Supervisor stack pointer |
| vbr | input | 32 | Vector table base |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| next_pc | output | 32 | Resulting PC |
| next_sr | output | 16 | Resulting SR |
| next_sp | output | 32 | Resulting SP |
| mem_valid | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Longword address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts/returns this cycle |
| mem_rdata | input | 32 | Read data, valid with ready |

## Verification
The assertions assume that the memory side raises ready only while a request is up. They also assume that the core gives a longword-aligned SP for return requests. The bench memory model answers only pending requests and always uses aligned stack pointers on returns. The interrupt-gate property assumes that no return request arrives in the same cycle, and the masked-interrupt scenarios keep rte_valid low to stay within that assumption.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int XLEN     = 32;
  localparam int SR_W     = 16;
  localparam int LVL_W    = 3;
  localparam int SR_S_BIT = 13;
  localparam int SR_M_BIT = 12;
  localparam int SR_I_LO  = 8;
  localparam logic [3:0] FMT_TAG = 4'h4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_PUSH_PC,
    ST_PUSH_FMT,
    ST_FETCH_VEC,
    ST_DONE,
    ST_RTE_FMT,
    ST_RTE_PC
  } seq_state_e;

  // Round a stack pointer down to a longword boundary.
  function automatic logic [XLEN-1:0] align_down4(input logic [XLEN-1:0] sp);
    return {sp[XLEN-1:2], 2'b00};
  endfunction

  // Assemble the format longword: tag, SP low bits, vector offset, old SR.
  function automatic logic [XLEN-1:0] frame_word(input logic [XLEN-1:0] voff,
                                                 input logic [SR_W-1:0] sr,
                                                 input logic [1:0]      low2);
    logic [XLEN-1:0] w;
    w        = {FMT_TAG, 28'h0};
    w[29:28] = low2;
    w[25:16] = voff[9:0];
    w[15:0]  = sr;
    return w;
  endfunction

  // SR seen by the handler.
  function automatic logic [SR_W-1:0] entry_sr(input logic [SR_W-1:0]  sr,
                                               input logic             is_irq,
                                               input logic [LVL_W-1:0] lvl);
    logic [SR_W-1:0] s;
    s = sr;
    s[SR_S_BIT] = 1'b1;
    if (is_irq) begin
      s[SR_I_LO +: LVL_W] = lvl;
      s[SR_M_BIT]         = 1'b0;
    end
    return s;
  endfunction

  // SP after popping a frame, restoring the original low bits.
  function automatic logic [XLEN-1:0] popped_sp(input logic [XLEN-1:0] sp,
                                                input logic [XLEN-1:0] fmt);
    return (sp | {30'b0, fmt[29:28]}) + 32'd8;
  endfunction

endpackage

// File: rtl/exc_seq_accept.sv
module exc_seq_accept
  import exc_seq_pkg::*;
(
  input  logic             idle,
  input  logic             exc_valid,
  input  logic             exc_irq,
  input  logic [LVL_W-1:0] exc_level,
  input  logic [LVL_W-1:0] cur_mask,
  input  logic             rte_valid,
  output logic             take_exc,
  output logic             take_rte,
  output logic             irq_masked
);

  always_comb begin
    irq_masked = exc_valid & exc_irq & (exc_level <= cur_mask);
    take_exc   = idle & exc_valid & ~irq_masked;
    take_rte   = idle & rte_valid & ~take_exc;
  end

endmodule

// File: rtl/exc_seq_frame.sv
module exc_seq_frame
  import exc_seq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [SR_W-1:0]  sr,
  input  logic [XLEN-1:0]  sp,
  input  logic             is_irq,
  input  logic [LVL_W-1:0] lvl,
  output logic [XLEN-1:0]  fmt,
  output logic [SR_W-1:0]  sr_new,
  output logic [XLEN-1:0]  sp_base,
  output logic [XLEN-1:0]  voff
);

  localparam int PAD_W = XLEN - VEC_W - 2;

  always_comb begin
    voff    = {{PAD_W{1'b0}}, vec, 2'b00};
    sp_base = align_down4(sp);
    fmt     = frame_word(voff, sr, sp[1:0]);
    sr_new  = entry_sr(sr, is_irq, lvl);
  end

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_seq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_valid,
  input  logic [VEC_W-1:0] exc_vector,
  input  logic             exc_irq,
  input  logic [2:0]       exc_level,
  input  logic             exc_trap,
  input  logic             rte_valid,
  input  logic [31:0]      cur_pc,
  input  logic [15:0]      cur_sr,
  input  logic [31:0]      cur_sp,
  input  logic [31:0]      vbr,
  output logic             busy,
  output logic             done,
  output logic [31:0]      next_pc,
  output logic [15:0]      next_sr,
  output logic [31:0]      next_sp,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata
);

  seq_state_e state;

  logic             take_exc, take_rte, irq_masked;
  logic [XLEN-1:0]  cap_pc, cap_sp, cap_vbr;
  logic [SR_W-1:0]  cap_sr;
  logic [VEC_W-1:0] cap_vec;
  logic             cap_irq;
  logic [LVL_W-1:0] cap_lvl;
  logic [XLEN-1:0]  fmt_c, sp_base_c, voff_c;
  logic [SR_W-1:0]  sr_new_c;
  logic [XLEN-1:0]  fmt_q, sp_base_q, vec_addr_q, rte_fmt_q;
  logic [SR_W-1:0]  sr_new_q;

  // Named events for the assertions.
  logic xfer, entry_fin, rte_fin;

  exc_seq_accept u_accept (
    .idle      (state == ST_IDLE),
    .exc_valid (exc_valid),
    .exc_irq   (exc_irq),
    .exc_level (exc_level),
    .cur_mask  (cur_sr[SR_I_LO +: LVL_W]),
    .rte_valid (rte_valid),
    .take_exc  (take_exc),
    .take_rte  (take_rte),
    .irq_masked(irq_masked)
  );

  exc_seq_frame #(.VEC_W(VEC_W)) u_frame (
    .vec    (cap_vec),
    .sr     (cap_sr),
    .sp     (cap_sp),
    .is_irq (cap_irq),
    .lvl    (cap_lvl),
    .fmt    (fmt_c),
    .sr_new (sr_new_c),
    .sp_base(sp_base_c),
    .voff   (voff_c)
  );

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_PC: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_base_q - 32'd4;
        mem_wdata = cap_pc;
      end
      ST_PUSH_FMT: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_base_q - 32'd8;
        mem_wdata = fmt_q;
      end
      ST_FETCH_VEC: begin
        mem_valid = 1'b1;
        mem_addr  = vec_addr_q;
      end
      ST_RTE_FMT: begin
        mem_valid = 1'b1;
        mem_addr  = align_down4(cap_sp);
      end
      ST_RTE_PC: begin
        mem_valid = 1'b1;
        mem_addr  = align_down4(cap_sp) + 32'd4;
      end
      default: ;
    endcase
  end

  assign xfer      = mem_valid & mem_ready;
  assign entry_fin = (state == ST_FETCH_VEC) & xfer;
  assign rte_fin   = (state == ST_RTE_PC) & xfer;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cap_pc     <= '0;
      cap_sp     <= '0;
      cap_vbr    <= '0;
      cap_sr     <= '0;
      cap_vec    <= '0;
      cap_irq    <= 1'b0;
      cap_lvl    <= '0;
      fmt_q      <= '0;
      sp_base_q  <= '0;
      vec_addr_q <= '0;
      sr_new_q   <= '0;
      rte_fmt_q  <= '0;
      next_pc    <= '0;
      next_sr    <= '0;
      next_sp    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_exc) begin
            cap_pc  <= exc_trap ? cur_pc + 32'd2 : cur_pc;
            cap_sr  <= cur_sr;
            cap_sp  <= cur_sp;
            cap_vbr <= vbr;
            cap_vec <= exc_vector;
            cap_irq <= exc_irq;
            cap_lvl <= exc_level;
            state   <= ST_ALIGN;
          end else if (take_rte) begin
            cap_sp  <= cur_sp;
            state   <= ST_RTE_FMT;
          end
        end
        ST_ALIGN: begin
          fmt_q      <= fmt_c;
          sp_base_q  <= sp_base_c;
          sr_new_q   <= sr_new_c;
          vec_addr_q <= cap_vbr + voff_c;
          state      <= ST_PUSH_PC;
        end
        ST_PUSH_PC:  if (xfer) state <= ST_PUSH_FMT;
        ST_PUSH_FMT: if (xfer) state <= ST_FETCH_VEC;
        ST_FETCH_VEC: begin
          if (xfer) begin
            next_pc <= mem_rdata;
            next_sr <= sr_new_q;
            next_sp <= sp_base_q - 32'd8;
            state   <= ST_DONE;
          end
        end
        ST_RTE_FMT: begin
          if (xfer) begin
            rte_fmt_q <= mem_rdata;
            state     <= ST_RTE_PC;
          end
        end
        ST_RTE_PC: begin
          if (xfer) begin
            next_pc <= mem_rdata;
            next_sr <= rte_fmt_q[15:0];
            next_sp <= popped_sp(cap_sp, rte_fmt_q);
            state   <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a pending request holds steady until ready.
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  // R2: every memory access is longword aligned.
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  // R9: done lasts exactly one cycle.
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: no memory traffic while idle.
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  // R4: the handler always runs in supervisor mode.
  assert_super_R4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fin |=> next_sr[SR_S_BIT]);

  // R5: an interrupt at or below the mask never starts a sequence.
  assert_irq_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && exc_valid && exc_irq && !rte_valid &&
     (exc_level <= cur_sr[10:8])) |=> !busy);

  // R7: a return ends in the done pulse.
  assert_rte_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rte_fin |=> done);

endmodule

// File: tb/exc_frame_seq_test.sv
module exc_frame_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [7:0]  exc_vector = '0;
  logic        exc_irq = 1'b0;
  logic [2:0]  exc_level = '0;
  logic        exc_trap = 1'b0;
  logic        rte_valid = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [15:0] cur_sr = '0;
  logic [31:0] cur_sp = '0;
  logic [31:0] vbr = '0;
  logic        busy, done;
  logic [31:0] next_pc, next_sp;
  logic [15:0] next_sr;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  exc_frame_seq uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Memory model state and transaction log.
  int          delay = 0;
  int          wcnt = 0;
  int          ntx = 0;
  int          rd_ptr = 0;
  logic [31:0] rd_data [0:1];
  logic [31:0] log_addr [0:7];
  logic [31:0] log_data [0:7];
  logic        log_we [0:7];
  logic [31:0] first_addr;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Responder: acts on falling edges only.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ready = 1'b0;
        wcnt = 0;
      end else if (mem_ready) begin
        mem_ready = 1'b0;
        wcnt = 0;
      end else if (mem_valid) begin
        if (wcnt == 0) first_addr = mem_addr;
        if (wcnt >= delay) begin
          if (delay > 0) check("R8 address held during stall", mem_addr, first_addr);
          mem_ready = 1'b1;
          if (ntx < 8) begin
            log_addr[ntx] = mem_addr;
            log_data[ntx] = mem_wdata;
            log_we[ntx]   = mem_we;
          end
          if (!mem_we) begin
            mem_rdata = rd_data[rd_ptr];
            log_data[ntx < 8 ? ntx : 7] = rd_data[rd_ptr];
            rd_ptr = (rd_ptr + 1) % 2;
          end
          ntx++;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    checks++;
    if (!seen) begin
      errors++;
      $display("FAIL %s done never seen actual 0 expected 1", tag);
    end
  endtask

  task automatic after_done(input string tag);
    @(negedge clk);
    check({tag, " R9 done single pulse"}, {31'b0, done}, 32'd0);
    check({tag, " R9 idle after done"}, {31'b0, busy}, 32'd0);
  endtask

  task automatic run_entry(input string tag, input logic [31:0] pc, input logic [15:0] sr,
                           input logic [31:0] sp, input logic [7:0] vec, input logic irq,
                           input logic [2:0] lvl, input logic trap, input int d,
                           input logic [31:0] base, input logic [31:0] handler);
    logic [31:0] spa, ret, fmt;
    logic [15:0] esr;
    spa = sp & 32'hFFFF_FFFC;
    ret = trap ? pc + 2 : pc;
    fmt = 32'h4000_0000 | ((sp & 32'h3) << 28) | ({24'b0, vec} << 18) | {16'b0, sr};
    esr = sr | 16'h2000;
    if (irq) esr = (esr & 16'hE8FF) | ({13'b0, lvl} << 8);
    rd_data[0] = handler;
    rd_ptr = 0; ntx = 0; delay = d;
    @(negedge clk);
    cur_pc = pc; cur_sr = sr; cur_sp = sp; vbr = base;
    exc_vector = vec; exc_irq = irq; exc_level = lvl; exc_trap = trap;
    exc_valid = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0;
    check({tag, " R9 busy after accept"}, {31'b0, busy}, 32'd1);
    wait_done(tag);
    check({tag, " R2 transfer count"}, ntx, 3);
    check({tag, " R2 first is write"}, {31'b0, log_we[0]}, 32'd1);
    check({tag, " R2 pc slot"}, log_addr[0], spa - 4);
    check({tag, " R6 stacked pc"}, log_data[0], ret);
    check({tag, " R2 fmt slot"}, log_addr[1], spa - 8);
    check({tag, " R1 format word"}, log_data[1], fmt);
    check({tag, " R3 vector read"}, {31'b0, log_we[2]}, 32'd0);
    check({tag, " R3 vector address"}, log_addr[2], base + {22'b0, vec, 2'b00});
    check({tag, " R3 new pc"}, next_pc, handler);
    check({tag, " R4 new sr"}, {16'b0, next_sr}, {16'b0, esr});
    check({tag, " R2 new sp"}, next_sp, spa - 8);
    after_done(tag);
  endtask

  task automatic run_rte(input string tag, input logic [31:0] sp, input logic [31:0] fmt,
                         input logic [31:0] pc, input int d);
    rd_data[0] = fmt; rd_data[1] = pc;
    rd_ptr = 0; ntx = 0; delay = d;
    @(negedge clk);
    cur_sp = sp;
    rte_valid = 1'b1;
    @(negedge clk);
    rte_valid = 1'b0;
    wait_done(tag);
    check({tag, " R7 transfer count"}, ntx, 2);
    check({tag, " R7 fmt read addr"}, log_addr[0], sp);
    check({tag, " R7 pc read addr"}, log_addr[1], sp + 4);
    check({tag, " R7 reads only"}, {30'b0, log_we[0], log_we[1]}, 32'd0);
    check({tag, " R7 pc"}, next_pc, pc);
    check({tag, " R7 sr"}, {16'b0, next_sr}, {16'b0, fmt[15:0]});
    check({tag, " R7 sp"}, next_sp, sp + {30'b0, fmt[29:28]} + 8);
    after_done(tag);
  endtask

  task automatic run_masked(input string tag, input logic [15:0] sr, input logic [2:0] lvl);
    ntx = 0; delay = 0;
    @(negedge clk);
    cur_sr = sr; exc_irq = 1'b1; exc_level = lvl; exc_trap = 1'b0;
    exc_valid = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0;
    check({tag, " R5 no busy"}, {31'b0, busy}, 32'd0);
    repeat (6) @(negedge clk);
    check({tag, " R5 no memory access"}, ntx, 0);
    check({tag, " R5 still idle"}, {30'b0, busy, done}, 32'd0);
  endtask

  task automatic run_busy_ignore();
    rd_data[0] = 32'h0000_7700;
    rd_ptr = 0; ntx = 0; delay = 3;
    @(negedge clk);
    cur_pc = 32'h0000_2000; cur_sr = 16'h0000; cur_sp = 32'h0000_9000; vbr = 32'h0;
    exc_vector = 8'd9; exc_irq = 1'b0; exc_trap = 1'b0;
    exc_valid = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0;
    repeat (2) @(negedge clk);
    exc_vector = 8'd40; exc_valid = 1'b1; rte_valid = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0; rte_valid = 1'b0;
    wait_done("busy ignore");
    check("R9 vector unchanged by late request", log_addr[2], 32'd36);
    after_done("busy ignore");
    repeat (4) @(negedge clk);
    check("R9 late requests dropped", ntx, 3);
  endtask

  task automatic run_collision();
    rd_data[0] = 32'h0000_5500;
    rd_ptr = 0; ntx = 0; delay = 0;
    @(negedge clk);
    cur_pc = 32'h0000_3000; cur_sr = 16'h0000; cur_sp = 32'h0000_A000; vbr = 32'h0;
    exc_vector = 8'd4; exc_irq = 1'b0; exc_trap = 1'b0;
    exc_valid = 1'b1; rte_valid = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0; rte_valid = 1'b0;
    wait_done("collision");
    check("R11 exception wins: first access is write", {31'b0, log_we[0]}, 32'd1);
    check("R11 exception wins: new pc", next_pc, 32'h0000_5500);
    after_done("collision");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 busy in reset", {31'b0, busy}, 32'd0);
    check("R10 mem_valid in reset", {31'b0, mem_valid}, 32'd0);
    check("R10 done in reset", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {30'b0, busy, mem_valid}, 32'd0);

    run_entry("plain", 32'h0000_1000, 16'h0004, 32'h8000_0010, 8'd5, 1'b0, 3'd0, 1'b0, 0,
              32'h0001_0000, 32'h0000_4400);
    run_entry("trap odd sp", 32'h0000_1234, 16'h0011, 32'h0000_4003, 8'd33, 1'b0, 3'd0, 1'b1, 2,
              32'h0000_0000, 32'h0000_8800);
    run_entry("irq", 32'h0000_2222, 16'h1200, 32'h0000_6002, 8'd29, 1'b1, 3'd5, 1'b0, 1,
              32'h0002_0000, 32'h0000_CC00);
    run_entry("irq level 7", 32'h0000_0040, 16'h3600, 32'h0000_7001, 8'd31, 1'b1, 3'd7, 1'b0, 0,
              32'h0000_0400, 32'h0000_0F00);
    run_masked("equal level", 16'h0300, 3'd3);
    run_masked("lower level", 16'h0300, 3'd2);
    run_masked("mask seven", 16'h0700, 3'd7);
    run_rte("rte odd", 32'h0000_3FF8, 32'h7084_0011, 32'h0000_1236, 0);
    run_rte("rte even", 32'h0000_5000, 32'h4014_A704, 32'h0000_9ABC, 3);
    run_busy_ignore();
    run_collision();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule